// File: doc/BRIEF.md
# Configuration Address Type Translator

This block sits on the downstream side of a bridge. It turns an upstream Type 1 configuration request that targets the bus directly below into a Type 0 request for that bus. The device number field of the incoming address becomes a one-hot device-select pattern in the upper half of the outgoing address. The function and register fields are copied across unchanged. The device-number field and the two type bits are cleared. A write to device 31 with a zero register field becomes a special-cycle broadcast instead of a configuration access.

Each request runs as a delayed transaction, and only one can be in flight at a time. The first attempt is latched and answered with retry, and the translated request is raised on the downstream side. Every later attempt is also retried until the downstream completion has been captured. After that, the first attempt that matches the latched address, command and byte enables receives the read data and the final status, and the block returns to idle. A request for which no device-select bit can be driven is still forwarded, but it always ends with master-abort status. Each access moves exactly one dword. If the upstream master asks for a second data phase, it is disconnected and a one-cycle flag is raised.

The controller has three states:
- `ST_IDLE` waits for a request it can accept.
- `ST_FWD` drives the downstream request until it is acknowledged.
- `ST_HOLD` keeps the captured completion until a matching repeat arrives.

The transitions are:
- `ST_IDLE`→`ST_FWD` when a request is accepted.
- `ST_FWD`→`ST_HOLD` on the downstream acknowledge.
- `ST_HOLD`→`ST_IDLE` when a matching repeat is answered.

Top module: `cfg_xlat_top`

## Requirements
- R1: For device number d = up_addr[15:11] in 0..15, dn_addr[31:16] has only bit d set (dn_addr[16+d] = 1), and dn_idsel equals dn_addr[31:16].
- R2: For device numbers 16..30, dn_addr[31:16] and dn_idsel are zero. The request is still driven downstream, and its completion is reported as master abort (rsp_code 2) whatever dn_mabort says.
- R3: A configuration write (up_cmd 4'hB) to device 31 with up_addr[7:2] = 0 raises dn_special and drives dn_cmd 4'h1 with dn_addr[31:16] = 0. Its completion is reported as done (rsp_code 1) unless dn_mabort is set. Device 31 with any other register field is a plain access with no select bit.
- R4: dn_addr[15:11] = 0 and dn_addr[1:0] = 2'b00, and dn_addr[10:2] = up_addr[10:2]. A request is accepted only when up_cmd is 4'hA (read) or 4'hB (write) and up_addr[1:0] = 2'b01. Any other request is ignored: it gets no rsp_valid and raises no dn_req.
- R5: An accepted request in idle gets rsp_valid with rsp_code 0 (retry) in the cycle after the up_req edge. dn_req rises in that same cycle. dn_req stays high, with dn_addr, dn_cmd, dn_be and dn_wdata held, until the cycle in which dn_ack is sampled.
- R6: Before dn_ack, a repeat of the latched request is retried. After dn_ack, the first repeat whose address, command and byte enables all match gets rsp_code 1 with rsp_rdata equal to the dn_rdata captured at dn_ack. It gets rsp_code 2 instead if dn_mabort was set at dn_ack or no select bit was driven. The block then returns to idle.
- R7: While a request is latched, any different accepted request is retried and not latched. dn_addr is unchanged, and the different request never receives a completion.
- R8: A completion (rsp_code 1 or 2) answered to a request with up_last = 0 also sets rsp_disc and pulses burst_trunc for exactly one cycle.
- R9: After reset, rsp_valid, dn_req, dn_special, rsp_disc and burst_trunc are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_req | input | 1 | Upstream attempt strobe, one cycle per attempt |
| up_addr | input | 32 | Upstream Type 1 address |
| up_cmd | input | 4 | Upstream command |
| up_be | input | 4 | Upstream byte enables |
| up_wdata | input | 32 | Upstream write data |
| up_last | input | 1 | Attempt has only one data phase |
| rsp_valid | output | 1 | Response to the previous attempt is valid |
| rsp_code | output | 2 | 0 retry, 1 done, 2 master abort |
| rsp_rdata | output | 32 | Read data returned with a completion |
| rsp_disc | output | 1 | Disconnect after the first dword |
| burst_trunc | output | 1 | One-cycle burst-truncated flag |
| dn_req | output | 1 | Downstream request |
| dn_addr | output | 32 | Translated Type 0 address |
| dn_cmd | output | 4 | Downstream command |
| dn_be | output | 4 | Downstream byte enables |
| dn_wdata | output | 32 | Downstream write data |
| dn_idsel | output | 16 | One-hot device select, equal to dn_addr[31:16] |
| dn_special | output | 1 | Downstream access is a special cycle |
| dn_ack | input | 1 | Downstream completion strobe |
| dn_mabort | input | 1 | Downstream completion ended in master abort |
| dn_rdata | input | 32 | Downstream read data |

## Verification
Every upstream attempt is sampled at a rising edge, and its response is registered and due one cycle later. The same edge that accepts a request raises dn_req and the translated address. A downstream acknowledge moves the captured status into the hold state at its edge, so the very next repeat can already complete. Inputs are driven on the falling edge and held across one rising edge. Outputs are read on the following falling edge, which is exactly when the registered response of that edge is visible. The downstream target is modelled by tasks that pulse dn_ack the same way.

// File: rtl/cfg_xlat_pkg.sv
package cfg_xlat_pkg;
    localparam logic [3:0] CMD_CFG_RD  = 4'hA;
    localparam logic [3:0] CMD_CFG_WR  = 4'hB;
    localparam logic [3:0] CMD_SPECIAL = 4'h1;

    typedef enum logic [1:0] {
        RSP_RETRY  = 2'd0,
        RSP_DONE   = 2'd1,
        RSP_MABORT = 2'd2
    } rsp_code_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FWD  = 2'd1,
        ST_HOLD = 2'd2
    } xlat_state_e;
endpackage

// File: rtl/cfg_addr_xlat.sv
module cfg_addr_xlat
    import cfg_xlat_pkg::*;
#(
    parameter int IDSEL_N = 16
) (
    input  logic [15:0]        src_lo,
    input  logic [3:0]         src_cmd,
    output logic               is_type1,
    output logic [15:0]        xl_lo,
    output logic [IDSEL_N-1:0] xl_sel,
    output logic [3:0]         xl_cmd,
    output logic               xl_special,
    output logic               xl_nosel
);
    localparam int DEV_W = 5;
    localparam logic [DEV_W-1:0] DEV_BCAST = '1;

    logic [DEV_W-1:0] dev;
    assign dev = src_lo[15:11];

    assign is_type1 = (src_lo[1:0] == 2'b01) &&
                      ((src_cmd == CMD_CFG_RD) || (src_cmd == CMD_CFG_WR));

    assign xl_special = (dev == DEV_BCAST) && (src_lo[7:2] == 6'd0) &&
                        (src_cmd == CMD_CFG_WR);

    for (genvar g = 0; g < IDSEL_N; g++) begin : g_sel
        assign xl_sel[g] = (dev == DEV_W'(g));
    end

    assign xl_nosel = ~|xl_sel;
    assign xl_lo    = {5'd0, src_lo[10:2], 2'b00};
    assign xl_cmd   = xl_special ? CMD_SPECIAL : src_cmd;
endmodule

// File: rtl/cfg_req_match.sv
module cfg_req_match #(
    parameter int ADDR_W = 32,
    parameter int BE_W   = 4
) (
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [3:0]        a_cmd,
    input  logic [BE_W-1:0]   a_be,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [3:0]        b_cmd,
    input  logic [BE_W-1:0]   b_be,
    output logic              same
);
    assign same = (a_addr == b_addr) && (a_cmd == b_cmd) && (a_be == b_be);
endmodule

// File: rtl/cfg_xlat_top.sv
module cfg_xlat_top
    import cfg_xlat_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int IDSEL_N = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               up_req,
    input  logic [ADDR_W-1:0]  up_addr,
    input  logic [3:0]         up_cmd,
    input  logic [3:0]         up_be,
    input  logic [DATA_W-1:0]  up_wdata,
    input  logic               up_last,
    output logic               rsp_valid,
    output logic [1:0]         rsp_code,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic               rsp_disc,
    output logic               burst_trunc,
    output logic               dn_req,
    output logic [ADDR_W-1:0]  dn_addr,
    output logic [3:0]         dn_cmd,
    output logic [3:0]         dn_be,
    output logic [DATA_W-1:0]  dn_wdata,
    output logic [IDSEL_N-1:0] dn_idsel,
    output logic               dn_special,
    input  logic               dn_ack,
    input  logic               dn_mabort,
    input  logic [DATA_W-1:0]  dn_rdata
);
    localparam int SEL_LSB = 16;
    localparam int UPPER_W = ADDR_W - SEL_LSB;

    xlat_state_e state, nxt;

    logic               is_type1, xl_special, xl_nosel, hit;
    logic [15:0]        xl_lo;
    logic [IDSEL_N-1:0] xl_sel;
    logic [3:0]         xl_cmd;
    logic [UPPER_W-1:0] xl_upper;

    logic [ADDR_W-1:0]  lat_addr;
    logic [3:0]         lat_cmd;
    logic               lat_nosel;
    logic [DATA_W-1:0]  cap_rdata;
    logic               cap_abort;
    logic               accept;

    cfg_addr_xlat #(.IDSEL_N(IDSEL_N)) u_xlat (
        .src_lo     (up_addr[15:0]),
        .src_cmd    (up_cmd),
        .is_type1   (is_type1),
        .xl_lo      (xl_lo),
        .xl_sel     (xl_sel),
        .xl_cmd     (xl_cmd),
        .xl_special (xl_special),
        .xl_nosel   (xl_nosel)
    );

    cfg_req_match #(.ADDR_W(ADDR_W), .BE_W(4)) u_match (
        .a_addr (lat_addr),
        .a_cmd  (lat_cmd),
        .a_be   (dn_be),
        .b_addr (up_addr),
        .b_cmd  (up_cmd),
        .b_be   (up_be),
        .same   (hit)
    );

    always_comb begin
        xl_upper = '0;
        xl_upper[IDSEL_N-1:0] = xl_sel;
    end

    assign accept   = up_req && is_type1;
    assign dn_req   = (state == ST_FWD);
    assign dn_idsel = dn_addr[SEL_LSB +: IDSEL_N];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (accept)        nxt = ST_FWD;
            ST_FWD:  if (dn_ack)        nxt = ST_HOLD;
            ST_HOLD: if (accept && hit) nxt = ST_IDLE;
            default:                    nxt = ST_IDLE;
        endcase
    end

    // outputs and latched request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_code    <= RSP_RETRY;
            rsp_rdata   <= '0;
            rsp_disc    <= 1'b0;
            burst_trunc <= 1'b0;
            dn_addr     <= '0;
            dn_cmd      <= '0;
            dn_be       <= '0;
            dn_wdata    <= '0;
            dn_special  <= 1'b0;
            lat_addr    <= '0;
            lat_cmd     <= '0;
            lat_nosel   <= 1'b0;
            cap_rdata   <= '0;
            cap_abort   <= 1'b0;
        end else begin
            rsp_valid   <= accept;
            rsp_code    <= RSP_RETRY;
            rsp_rdata   <= '0;
            rsp_disc    <= 1'b0;
            burst_trunc <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        lat_addr   <= up_addr;
                        lat_cmd    <= up_cmd;
                        lat_nosel  <= xl_nosel && !xl_special;
                        dn_addr    <= {xl_upper, xl_lo};
                        dn_cmd     <= xl_cmd;
                        dn_be      <= up_be;
                        dn_wdata   <= up_wdata;
                        dn_special <= xl_special;
                    end
                end
                ST_FWD: begin
                    if (dn_ack) begin
                        cap_rdata <= dn_rdata;
                        cap_abort <= lat_nosel || dn_mabort;
                    end
                end
                ST_HOLD: begin
                    if (accept && hit) begin
                        rsp_code    <= cap_abort ? RSP_MABORT : RSP_DONE;
                        rsp_rdata   <= cap_rdata;
                        rsp_disc    <= !up_last;
                        burst_trunc <= !up_last;
                        dn_special  <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cfg_xlat_chk.sv
module cfg_xlat_chk #(
    parameter int ADDR_W  = 32,
    parameter int IDSEL_N = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rsp_valid,
    input logic [1:0]         rsp_code,
    input logic               rsp_disc,
    input logic               burst_trunc,
    input logic               dn_req,
    input logic [ADDR_W-1:0]  dn_addr,
    input logic [IDSEL_N-1:0] dn_idsel,
    input logic               dn_special,
    input logic               dn_ack
);
    // R1: at most one select bit
    assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req |-> $onehot0(dn_idsel));

    // R3: special cycle drives no select bit
    assert_special_nosel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && dn_special) |-> (dn_idsel == '0));

    // R4: type and device fields cleared
    assert_type0_fields_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req |-> (dn_addr[1:0] == 2'b00 && dn_addr[15:11] == 5'd0));

    // R5: request held with stable address until acknowledged
    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && !dn_ack) |=> (dn_req && $stable(dn_addr)));

    // R6: no completion while the downstream request is outstanding
    assert_no_early_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req |-> !(rsp_valid && rsp_code != 2'd0));

    // R8: truncation flag comes with a completion and a disconnect, one cycle long
    assert_trunc_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        burst_trunc |-> (rsp_valid && rsp_code != 2'd0 && rsp_disc));
    assert_trunc_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        burst_trunc |=> !burst_trunc);
endmodule

bind cfg_xlat_top cfg_xlat_chk #(.ADDR_W(ADDR_W), .IDSEL_N(IDSEL_N)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rsp_valid   (rsp_valid),
    .rsp_code    (rsp_code),
    .rsp_disc    (rsp_disc),
    .burst_trunc (burst_trunc),
    .dn_req      (dn_req),
    .dn_addr     (dn_addr),
    .dn_idsel    (dn_idsel),
    .dn_special  (dn_special),
    .dn_ack      (dn_ack)
);

// File: tb/tb_cfg_xlat_top.sv
module tb_cfg_xlat_top;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        up_req = 1'b0;
    logic [31:0] up_addr = '0;
    logic [3:0]  up_cmd = '0;
    logic [3:0]  up_be = '0;
    logic [31:0] up_wdata = '0;
    logic        up_last = 1'b1;
    logic        rsp_valid, rsp_disc, burst_trunc;
    logic [1:0]  rsp_code;
    logic [31:0] rsp_rdata;
    logic        dn_req, dn_special;
    logic [31:0] dn_addr, dn_wdata;
    logic [3:0]  dn_cmd, dn_be;
    logic [15:0] dn_idsel;
    logic        dn_ack = 1'b0;
    logic        dn_mabort = 1'b0;
    logic [31:0] dn_rdata = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_xlat_top dut (
        .clk(clk), .rst_n(rst_n), .up_req(up_req), .up_addr(up_addr),
        .up_cmd(up_cmd), .up_be(up_be), .up_wdata(up_wdata), .up_last(up_last),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_rdata(rsp_rdata),
        .rsp_disc(rsp_disc), .burst_trunc(burst_trunc), .dn_req(dn_req),
        .dn_addr(dn_addr), .dn_cmd(dn_cmd), .dn_be(dn_be), .dn_wdata(dn_wdata),
        .dn_idsel(dn_idsel), .dn_special(dn_special), .dn_ack(dn_ack),
        .dn_mabort(dn_mabort), .dn_rdata(dn_rdata)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    function automatic logic [31:0] t1addr(input int dev, input int fn, input int rg);
        return {8'h00, 8'h01, 5'(dev), 3'(fn), 6'(rg), 2'b01};
    endfunction

    function automatic logic [31:0] t0addr(input int dev, input int fn, input int rg);
        logic [31:0] a;
        a = {21'd0, 3'(fn), 6'(rg), 2'b00};
        if (dev < 16) a[16 + dev] = 1'b1;
        return a;
    endfunction

    // one upstream attempt; returns the registered response
    task automatic attempt(input logic [31:0] a, input logic [3:0] c, input logic [3:0] be,
                           input logic [31:0] wd, input logic last,
                           output logic v, output logic [1:0] code, output logic [31:0] rd,
                           output logic disc, output logic bt);
        @(negedge clk);
        up_addr = a; up_cmd = c; up_be = be; up_wdata = wd; up_last = last; up_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        up_req = 1'b0; up_last = 1'b1;
        v = rsp_valid; code = rsp_code; rd = rsp_rdata; disc = rsp_disc; bt = burst_trunc;
    endtask

    task automatic dn_complete(input logic mab, input logic [31:0] rd, input string tag);
        @(negedge clk);
        check({31'd0, dn_req}, 32'd1, {tag, " dn_req before ack"});
        dn_ack = 1'b1; dn_mabort = mab; dn_rdata = rd;
        @(posedge clk);
        @(negedge clk);
        dn_ack = 1'b0; dn_mabort = 1'b0;
        check({31'd0, dn_req}, 32'd0, {tag, " dn_req drops after ack"});
    endtask

    // full delayed transaction: first attempt, downstream completion, matching repeat
    task automatic run_txn(input int dev, input int rg, input logic [3:0] cmd, input logic mab,
                           input logic [1:0] exp_code, input string tag);
        logic v, disc, bt; logic [1:0] code; logic [31:0] rd, a, dat;
        a = t1addr(dev, 3, rg);
        dat = 32'hA500_0000 + 32'(dev);
        attempt(a, cmd, 4'hF, 32'h1234_0000 + 32'(dev), 1'b1, v, code, rd, disc, bt);
        check({31'd0, v}, 32'd1, {tag, " R5 first attempt valid"});
        check({30'd0, code}, 32'd0, {tag, " R5 first attempt retry"});
        check({31'd0, dn_req}, 32'd1, {tag, " R5 dn_req raised"});
        check(dn_addr, t0addr(dev, 3, rg), {tag, " R1/R4 dn_addr"});
        check({16'd0, dn_idsel}, {16'd0, t0addr(dev, 3, rg)[31:16]}, {tag, " R1 dn_idsel"});
        dn_complete(mab, dat, tag);
        attempt(a, cmd, 4'hF, 32'h1234_0000 + 32'(dev), 1'b1, v, code, rd, disc, bt);
        check({30'd0, code}, {30'd0, exp_code}, {tag, " R6 completion code"});
        if (exp_code == 2'd1) check(rd, dat, {tag, " R6 read data"});
        check({31'd0, disc}, 32'd0, {tag, " R8 no disconnect on single phase"});
    endtask

    task automatic t_reset;
        check({31'd0, rsp_valid}, 0, "R9 rsp_valid after reset");
        check({31'd0, dn_req}, 0, "R9 dn_req after reset");
        check({31'd0, dn_special}, 0, "R9 dn_special after reset");
        check({31'd0, burst_trunc}, 0, "R9 burst_trunc after reset");
        check({31'd0, rsp_disc}, 0, "R9 rsp_disc after reset");
    endtask

    task automatic t_select_sweep;
        for (int d = 0; d < 16; d++) run_txn(d, 4 + d, 4'hA, 1'b0, 2'd1, "R1 sweep");
    endtask

    task automatic t_high_dev;
        run_txn(20, 8, 4'hA, 1'b0, 2'd2, "R2 dev20");
        check({16'd0, dn_idsel}, 0, "R2 no select for dev20");
        run_txn(30, 0, 4'hB, 1'b0, 2'd2, "R2 dev30 write");
    endtask

    task automatic t_special;
        logic v, disc, bt; logic [1:0] code; logic [31:0] rd;
        attempt(t1addr(31, 5, 0), 4'hB, 4'h3, 32'hCAFE_0001, 1'b1, v, code, rd, disc, bt);
        check({31'd0, dn_special}, 1, "R3 special raised");
        check({28'd0, dn_cmd}, 32'h1, "R3 special command");
        check({16'd0, dn_idsel}, 0, "R3 no select on special");
        check(dn_wdata, 32'hCAFE_0001, "R5 write data forwarded");
        check({28'd0, dn_be}, 32'h3, "R5 byte enables forwarded");
        dn_complete(1'b0, 32'd0, "R3 special");
        attempt(t1addr(31, 5, 0), 4'hB, 4'h3, 32'hCAFE_0001, 1'b1, v, code, rd, disc, bt);
        check({30'd0, code}, 1, "R3 special completes done");
        attempt(t1addr(31, 0, 1), 4'hB, 4'hF, 32'd0, 1'b1, v, code, rd, disc, bt);
        check({31'd0, dn_special}, 0, "R3 dev31 nonzero reg is not special");
        dn_complete(1'b0, 32'd0, "R3 dev31 reg1");
        attempt(t1addr(31, 0, 1), 4'hB, 4'hF, 32'd0, 1'b1, v, code, rd, disc, bt);
        check({30'd0, code}, 2, "R3 dev31 nonzero reg master abort");
    endtask

    task automatic t_pending;
        logic v, disc, bt; logic [1:0] code; logic [31:0] rd;
        attempt(t1addr(3, 1, 9), 4'hA, 4'hF, 32'd0, 1'b1, v, code, rd, disc, bt);
        attempt(t1addr(3, 1, 9), 4'hA, 4'hF, 32'd0, 1'b1, v, code, rd, disc, bt);
        check({30'd0, code}, 0, "R6 repeat before ack retried");
        attempt(t1addr(4, 0, 2), 4'hA, 4'hF, 32'd0, 1'b1, v, code, rd, disc, bt);
        check({31'd0, v}, 1, "R7 other request answered");
        check({30'd0, code}, 0, "R7 other request retried");
        check(dn_addr, t0addr(3, 1, 9), "R7 latched address unchanged");
        dn_complete(1'b0, 32'h0BAD_F00D, "R6 pending");
        attempt(t1addr(3, 1, 9), 4'hA, 4'h1, 32'd0, 1'b1, v, code, rd, disc, bt);
        check({30'd0, code}, 0, "R6 byte-enable mismatch retried");
        attempt(t1addr(4, 0, 2), 4'hA, 4'hF, 32'd0, 1'b1, v, code, rd, disc, bt);
        check({30'd0, code}, 0, "R7 other request never completes");
        attempt(t1addr(3, 1, 9), 4'hA, 4'hF, 32'd0, 1'b1, v, code, rd, disc, bt);
        check({30'd0, code}, 1, "R6 matching repeat done");
        check(rd, 32'h0BAD_F00D, "R6 matching repeat data");
        check({31'd0, dn_req}, 0, "R6 idle after completion");
        run_txn(2, 6, 4'hA, 1'b1, 2'd2, "R6 downstream abort");
    endtask

    task automatic t_burst;
        logic v, disc, bt; logic [1:0] code; logic [31:0] rd;
        attempt(t1addr(7, 2, 3), 4'hA, 4'hF, 32'd0, 1'b0, v, code, rd, disc, bt);
        check({30'd0, code}, 0, "R8 first burst attempt retried");
        check({31'd0, bt}, 0, "R8 no flag on retry");
        dn_complete(1'b0, 32'h7777_0007, "R8 burst");
        attempt(t1addr(7, 2, 3), 4'hA, 4'hF, 32'd0, 1'b0, v, code, rd, disc, bt);
        check({30'd0, code}, 1, "R8 burst completion done");
        check({31'd0, disc}, 1, "R8 disconnect");
        check({31'd0, bt}, 1, "R8 truncation flag");
        @(negedge clk);
        check({31'd0, burst_trunc}, 0, "R8 flag lasts one cycle");
    endtask

    task automatic t_ignored;
        logic v, disc, bt; logic [1:0] code; logic [31:0] rd;
        attempt(t1addr(1, 0, 0), 4'h6, 4'hF, 32'd0, 1'b1, v, code, rd, disc, bt);
        check({31'd0, v}, 0, "R4 memory command ignored");
        check({31'd0, dn_req}, 0, "R4 memory command not forwarded");
        attempt({t1addr(1, 0, 0)[31:2], 2'b00}, 4'hA, 4'hF, 32'd0, 1'b1, v, code, rd, disc, bt);
        check({31'd0, v}, 0, "R4 type 0 address ignored");
        check({31'd0, dn_req}, 0, "R4 type 0 address not forwarded");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_select_sweep();
        t_high_dev();
        t_special();
        t_pending();
        t_burst();
        t_ignored();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule